// File: doc/BRIEF.md
# Serial Flash Modify-Command Protection Gate

This block sits behind the SPI front end of a serial NOR flash slave and decides whether each data-modifying instruction may run. The front end hands it one decoded event per chip-select frame: the opcode, the 24-bit address field, the first data byte and the number of serial clock edges the frame contained. The gate also sees the hardware write-protect pin and the power-good reset. It owns the write-enable latch, the three-bit protect code, the status-write-lock bit and the deep power-down state.

For every status write, page program, sector erase or chip erase that is not ignored, the gate emits a one-cycle verdict (accept or reject). An accepted command starts a job on the memory-array model through a start pulse, a job kind and the address, and the gate then reports busy until the array returns a done pulse. Completion clears the write-enable latch and, for a status write, commits the new protect code and lock bit. A rejected command changes no state.

The protect code names a read-only region at the top of a 16-sector array. Code 0 protects nothing, codes 1 to 4 protect the top 1, 2, 4 or 8 sectors, and codes 5 to 7 protect every sector. A chip erase needs a protect code of zero.

Top module: `flash_wp_gate`

## Requirements
- R1: After reset, busy, the write-enable latch, the protect code, the lock bit, deep power-down, pu_ready, res_valid and arr_start are all 0.
- R2: A modify command (status write 0x01, page program 0x02, sector erase 0xD8, chip erase 0xC7) arriving while the write-enable latch is clear gets res_valid=1 with res_ok=0, one cycle after cmd_valid.
- R3: Opcode 0x06 sets the write-enable latch and 0x04 clears it; a done pulse while busy clears both busy and the write-enable latch on the following edge.
- R4: A modify command whose cmd_edges value is not a multiple of eight (bits 2:0 not zero) is rejected.
- R5: A page program or sector erase is rejected when the sector in address bits 19:16 is protected: code 1 protects sector 15, 2 protects 14-15, 3 protects 12-15, 4 protects 8-15, codes 5-7 protect all sectors.
- R6: A chip erase is rejected unless all three protect bits are zero.
- R7: A status write takes the lock bit from data bit 7 and the protect code from data bits 4:2, committed on completion; it is rejected when the lock bit is 1 and wp_n is 0.
- R8: Until PU_CYCLES clock cycles have passed since reset release, pu_ready is 0 and every modify command is rejected; pu_ready then stays 1.
- R9: A rejected command leaves the write-enable latch and the protect state unchanged.
- R10: While busy, every command is ignored: no res_valid and no state change.
- R11: Opcode 0xB9 enters deep power-down; there every command except 0xAB is ignored, and 0xAB leaves deep power-down.
- R12: An accepted command pulses arr_start with res_ok=1 and drives arr_kind (0 status, 1 program, 2 sector erase, 3 chip erase) and arr_addr, and sets busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-good reset |
| cmd_valid | input | 1 | One-cycle pulse: a decoded frame ended |
| cmd_op | input | 8 | Decoded opcode |
| cmd_addr | input | ADDR_W | Address field of the frame |
| cmd_data | input | 8 | First data byte of the frame |
| cmd_edges | input | EDGE_W | Serial clock edges counted in the frame |
| wp_n | input | 1 | Hardware write-protect pin, active low |
| arr_done | input | 1 | Array job finished |
| pu_ready | output | 1 | Power-up delay has expired |
| res_valid | output | 1 | Verdict for a modify command |
| res_ok | output | 1 | Verdict: 1 accept, 0 reject |
| arr_start | output | 1 | Start pulse to the array |
| arr_kind | output | 2 | Kind of array job |
| arr_addr | output | ADDR_W | Address of the array job |
| busy | output | 1 | Job in progress |
| wel | output | 1 | Write-enable latch |
| bp | output | 3 | Protect code |
| srwd | output | 1 | Status-write lock bit |
| dpd | output | 1 | Deep power-down state |

## Verification
The bench aims at the protect-code boundaries (sector 11 against 12 under code 3, 14 against 15 under code 1, 7 against 8 under code 4, sector 0 under code 5), where an off-by-one decoder would accept a write into the read-only region or refuse a legal one. It drives frames one edge past a byte boundary, which a gate ignoring the frame length would accept, and it sends commands before the power-up delay ends, while busy and in deep power-down, where a leaky gate would produce a verdict or flip the latch. It toggles the write-protect pin against a set lock bit and checks that a refused status write keeps both the protect code and the write-enable latch, since a design that cleared the latch on rejection or committed the status early would show a changed value.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;

    localparam logic [7:0] OPC_SET_WEL    = 8'h06;
    localparam logic [7:0] OPC_CLR_WEL    = 8'h04;
    localparam logic [7:0] OPC_WR_STATUS  = 8'h01;
    localparam logic [7:0] OPC_PROGRAM    = 8'h02;
    localparam logic [7:0] OPC_SECT_ERASE = 8'hD8;
    localparam logic [7:0] OPC_CHIP_ERASE = 8'hC7;
    localparam logic [7:0] OPC_SLEEP      = 8'hB9;
    localparam logic [7:0] OPC_WAKE       = 8'hAB;

    localparam int SR_LOCK_BIT = 7;
    localparam int SR_BP_LSB   = 2;

    typedef enum logic [1:0] {
        JOB_STATUS  = 2'd0,
        JOB_PROGRAM = 2'd1,
        JOB_SECTOR  = 2'd2,
        JOB_CHIP    = 2'd3
    } job_e;

    typedef struct packed {
        logic       wel;
        logic [2:0] bp;
        logic       srwd;
        logic       dpd;
        logic       busy;
        job_e       job;
        logic [2:0] pend_bp;
        logic       pend_srwd;
        logic       res_valid;
        logic       res_ok;
        logic       arr_start;
    } gate_state_t;

endpackage

// File: rtl/flash_wp_pwrup.sv
module flash_wp_pwrup #(
    parameter int PU_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    output logic ready
);
    localparam int CNT_W = $clog2(PU_CYCLES + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             rdy;
    } pu_state_t;

    pu_state_t pu_d, pu_q;

    always_comb begin
        pu_d = pu_q;
        if (!pu_q.rdy) begin
            pu_d.cnt = pu_q.cnt + 1'b1;
            if (pu_q.cnt == CNT_W'(PU_CYCLES - 1)) begin
                pu_d.rdy = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pu_q <= '0;
        end else begin
            pu_q <= pu_d;
        end
    end

    assign ready = pu_q.rdy;

    AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        pu_q.rdy |=> pu_q.rdy); // R8

endmodule

// File: rtl/flash_wp_protdec.sv
module flash_wp_protdec #(
    parameter int SECTOR_BITS = 4
) (
    input  logic [2:0]             bp,
    input  logic [SECTOR_BITS-1:0] sector,
    output logic                   hit,
    output logic                   any
);
    localparam int NSECT = 1 << SECTOR_BITS;

    logic [NSECT-1:0] mask;

    generate
        for (genvar s = 0; s < NSECT; s++) begin : g_sec
            assign mask[s] = (bp != 3'd0) &&
                             ((32'(bp) > 32'(SECTOR_BITS)) ||
                              (32'(s) >= 32'(NSECT) - (32'd1 << (32'(bp) - 32'd1))));
        end
    endgenerate

    assign hit = mask[sector];
    assign any = |bp;

endmodule

// File: rtl/flash_wp_gate.sv
module flash_wp_gate
    import flash_wp_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int EDGE_W      = 16,
    parameter int SECTOR_BITS = 4,
    parameter int SECT_LSB    = 16,
    parameter int PU_CYCLES   = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_data,
    input  logic [EDGE_W-1:0] cmd_edges,
    input  logic              wp_n,
    input  logic              arr_done,
    output logic              pu_ready,
    output logic              res_valid,
    output logic              res_ok,
    output logic              arr_start,
    output logic [1:0]        arr_kind,
    output logic [ADDR_W-1:0] arr_addr,
    output logic              busy,
    output logic              wel,
    output logic [2:0]        bp,
    output logic              srwd,
    output logic              dpd
);
    gate_state_t       st_d, st_q;
    logic [ADDR_W-1:0] addr_d, addr_q;

    logic [SECTOR_BITS-1:0] cmd_sector;
    logic                   sect_hit;
    logic                   bp_any;
    logic                   edges_ok;
    logic                   ready;
    logic                   unused_bits;

    assign cmd_sector  = cmd_addr[SECT_LSB +: SECTOR_BITS];
    assign edges_ok    = (cmd_edges[2:0] == 3'd0);
    assign unused_bits = ^{cmd_data[6:5], cmd_data[1:0], cmd_edges[EDGE_W-1:3]};

    flash_wp_pwrup #(.PU_CYCLES(PU_CYCLES)) pwrup_i (
        .clk   (clk),
        .rst_n (rst_n),
        .ready (ready)
    );

    flash_wp_protdec #(.SECTOR_BITS(SECTOR_BITS)) protdec_i (
        .bp     (st_q.bp),
        .sector (cmd_sector),
        .hit    (sect_hit),
        .any    (bp_any)
    );

    always_comb begin
        logic gate_ok;
        st_d           = st_q;
        addr_d         = addr_q;
        st_d.res_valid = 1'b0;
        st_d.res_ok    = 1'b0;
        st_d.arr_start = 1'b0;
        gate_ok        = ready && st_q.wel && edges_ok;

        if (st_q.busy) begin
            if (arr_done) begin
                st_d.busy = 1'b0;
                st_d.wel  = 1'b0;
                if (st_q.job == JOB_STATUS) begin
                    st_d.bp   = st_q.pend_bp;
                    st_d.srwd = st_q.pend_srwd;
                end
            end
        end else if (cmd_valid) begin
            if (st_q.dpd) begin
                if (cmd_op == OPC_WAKE) begin
                    st_d.dpd = 1'b0;
                end
            end else begin
                case (cmd_op)
                    OPC_SET_WEL: st_d.wel = 1'b1;
                    OPC_CLR_WEL: st_d.wel = 1'b0;
                    OPC_SLEEP:   st_d.dpd = 1'b1;
                    OPC_WR_STATUS: begin
                        st_d.res_valid = 1'b1;
                        if (gate_ok && !(st_q.srwd && !wp_n)) begin
                            st_d.res_ok    = 1'b1;
                            st_d.busy      = 1'b1;
                            st_d.arr_start = 1'b1;
                            st_d.job       = JOB_STATUS;
                            st_d.pend_bp   = cmd_data[SR_BP_LSB +: 3];
                            st_d.pend_srwd = cmd_data[SR_LOCK_BIT];
                            addr_d         = cmd_addr;
                        end
                    end
                    OPC_PROGRAM: begin
                        st_d.res_valid = 1'b1;
                        if (gate_ok && !sect_hit) begin
                            st_d.res_ok    = 1'b1;
                            st_d.busy      = 1'b1;
                            st_d.arr_start = 1'b1;
                            st_d.job       = JOB_PROGRAM;
                            addr_d         = cmd_addr;
                        end
                    end
                    OPC_SECT_ERASE: begin
                        st_d.res_valid = 1'b1;
                        if (gate_ok && !sect_hit) begin
                            st_d.res_ok    = 1'b1;
                            st_d.busy      = 1'b1;
                            st_d.arr_start = 1'b1;
                            st_d.job       = JOB_SECTOR;
                            addr_d         = cmd_addr;
                        end
                    end
                    OPC_CHIP_ERASE: begin
                        st_d.res_valid = 1'b1;
                        if (gate_ok && !bp_any) begin
                            st_d.res_ok    = 1'b1;
                            st_d.busy      = 1'b1;
                            st_d.arr_start = 1'b1;
                            st_d.job       = JOB_CHIP;
                            addr_d         = cmd_addr;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= '0;
            addr_q <= '0;
        end else begin
            st_q   <= st_d;
            addr_q <= addr_d;
        end
    end

    assign pu_ready  = ready;
    assign res_valid = st_q.res_valid;
    assign res_ok    = st_q.res_ok;
    assign arr_start = st_q.arr_start;
    assign arr_kind  = st_q.job;
    assign arr_addr  = addr_q;
    assign busy      = st_q.busy;
    assign wel       = st_q.wel;
    assign bp        = st_q.bp;
    assign srwd      = st_q.srwd;
    assign dpd       = st_q.dpd;

    AST_OK_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.res_valid && st_q.res_ok) |-> $past(st_q.wel)); // R2

    AST_DONE_CLEARS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && arr_done) |=> (!st_q.busy && !st_q.wel)); // R3

    AST_WHOLE_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.res_valid && st_q.res_ok) |-> $past(cmd_edges[2:0] == 3'd0)); // R4

    AST_CHIP_ERASE_BP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OPC_CHIP_ERASE && st_q.bp != 3'd0) |=> !st_q.res_ok); // R6

    AST_OK_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.res_valid && st_q.res_ok) |-> $past(ready)); // R8

    AST_SILENT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.res_valid |-> !$past(st_q.busy)); // R10

    AST_DPD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.dpd && !(cmd_valid && cmd_op == OPC_WAKE)) |=> st_q.dpd); // R11

    AST_DPD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.dpd |=> !st_q.res_valid); // R11

    AST_START_PAIRS: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.arr_start |-> (st_q.res_valid && st_q.res_ok && st_q.busy)); // R12

endmodule

// File: tb/flash_wp_gate_tb.sv
module flash_wp_gate_tb_top;
    localparam int ADDR_W = 24;
    localparam int EDGE_W = 16;
    localparam int PU     = 20;

    localparam logic [7:0] C_WREN = 8'h06, C_WRDI = 8'h04, C_WRSR = 8'h01,
                           C_PP = 8'h02, C_SE = 8'hD8, C_BE = 8'hC7,
                           C_DP = 8'hB9, C_RES = 8'hAB;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [7:0]        cmd_op = '0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [7:0]        cmd_data = '0;
    logic [EDGE_W-1:0] cmd_edges = '0;
    logic              wp_n = 1'b1;
    logic              arr_done = 1'b0;
    logic              pu_ready, res_valid, res_ok, arr_start, busy, wel, srwd, dpd;
    logic [1:0]        arr_kind;
    logic [ADDR_W-1:0] arr_addr;
    logic [2:0]        bp;

    always #2 clk = ~clk;

    flash_wp_gate #(.ADDR_W(ADDR_W), .EDGE_W(EDGE_W), .PU_CYCLES(PU)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_edges(cmd_edges),
        .wp_n(wp_n), .arr_done(arr_done), .pu_ready(pu_ready),
        .res_valid(res_valid), .res_ok(res_ok), .arr_start(arr_start),
        .arr_kind(arr_kind), .arr_addr(arr_addr), .busy(busy), .wel(wel),
        .bp(bp), .srwd(srwd), .dpd(dpd)
    );

    typedef struct {
        bit    ok;
        string tag;
    } item_t;

    item_t sb[$];
    int    n_checks = 0;
    int    n_fail   = 0;
    bit    finished = 1'b0;

    function automatic void chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endfunction

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    endtask

    // monitor: pops the scoreboard on every verdict
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (sb.size() == 0) begin
                chk("R10/R11 unexpected verdict", 32'(res_valid), 32'd0);
            end else begin
                item_t it;
                it = sb.pop_front();
                chk(it.tag, 32'(res_ok), 32'(it.ok));
            end
        end
    end

    task automatic send(input logic [7:0] op, input logic [23:0] addr,
                        input logic [7:0] data, input int edges,
                        input bit want_resp, input bit want_ok, input string tag);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_addr  = addr;
        cmd_data  = data;
        cmd_edges = EDGE_W'(edges);
        if (want_resp) begin
            item_t it;
            it.ok  = want_ok;
            it.tag = tag;
            sb.push_back(it);
        end
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic complete();
        @(negedge clk);
        arr_done = 1'b1;
        @(negedge clk);
        arr_done = 1'b0;
        chk("R3 busy after done", 32'(busy), 32'd0);
        chk("R3 wel after done", 32'(wel), 32'd0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 wel", 32'(wel), 32'd0);
        chk("R1 bp", 32'(bp), 32'd0);
        chk("R1 srwd", 32'(srwd), 32'd0);
        chk("R1 dpd", 32'(dpd), 32'd0);
        chk("R1 res_valid", 32'(res_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pu_ready", 32'(pu_ready), 32'd0);

        // R8 modify before power-up delay
        send(C_WREN, 24'h0, 8'h0, 8, 0, 0, "");
        chk("R3 wren sets wel", 32'(wel), 32'd1);
        send(C_PP, 24'h00_0100, 8'hAA, 40, 1, 0, "R8 program before ready");
        chk("R9 wel kept after reject", 32'(wel), 32'd1);
        chk("R8 pu_ready early", 32'(pu_ready), 32'd0);
        repeat (PU + 2) @(negedge clk);
        chk("R8 pu_ready late", 32'(pu_ready), 32'd1);

        // R2 no latch
        send(C_WRDI, 24'h0, 8'h0, 8, 0, 0, "");
        chk("R3 wrdi clears wel", 32'(wel), 32'd0);
        send(C_PP, 24'h03_0000, 8'h11, 40, 1, 0, "R2 program without wel");

        // R4 partial byte
        send(C_WREN, 24'h0, 8'h0, 8, 0, 0, "");
        send(C_PP, 24'h03_0000, 8'h11, 41, 1, 0, "R4 41 edges");
        chk("R9 wel after R4 reject", 32'(wel), 32'd1);

        // R12 accept, R10 busy
        send(C_PP, 24'h03_0040, 8'h11, 40, 1, 1, "R12 program accept");
        chk("R12 arr_start", 32'(arr_start), 32'd1);
        chk("R12 arr_kind", 32'(arr_kind), 32'd1);
        chk("R12 arr_addr", 32'(arr_addr), 32'h03_0040);
        chk("R12 busy", 32'(busy), 32'd1);
        send(C_WRDI, 24'h0, 8'h0, 8, 0, 0, "");
        send(C_PP, 24'h04_0000, 8'h11, 40, 0, 0, "");
        chk("R10 wel untouched while busy", 32'(wel), 32'd1);
        complete();

        // R7 status write, commit at done
        send(C_WREN, 24'h0, 8'h0, 8, 0, 0, "");
        send(C_WRSR, 24'h0, 8'h0C, 16, 1, 1, "R7 status write code 3");
        chk("R12 arr_kind status", 32'(arr_kind), 32'd0);
        chk("R7 bp held until done", 32'(bp), 32'd0);
        complete();
        chk("R7 bp committed", 32'(bp), 32'd3);

        // R5 code 3: 12..15
        send(C_WREN, 24'h0, 8'h0, 8, 0, 0, "");
        send(C_PP, 24'h0C_0000, 8'h11, 40, 1, 0, "R5 code3 sector 12");
        send(C_PP, 24'h0B_FF00, 8'h11, 40, 1, 1, "R5 code3 sector 11");
        complete();

        // R6 chip erase with code set
        send(C_WREN, 24'h0, 8'h0, 8, 0, 0, "");
        send(C_BE, 24'h0, 8'h0, 8, 1, 0, "R6 chip erase code 3");
        send(C_SE, 24'h0F_0000, 8'h0, 32, 1, 0, "R5 code3 sector 15");
        send(C_WRSR, 24'h0, 8'h90, 16, 1, 1, "R7 lock and code 4");
        complete();
        chk("R7 srwd set", 32'(srwd), 32'd1);
        chk("R7 bp 4", 32'(bp), 32'd4);

        // R7 hardware protection
        wp_n = 1'b0;
        send(C_WREN, 24'h0, 8'h0, 8, 0, 0, "");
        send(C_WRSR, 24'h0, 8'h00, 16, 1, 0, "R7 locked status write");
        chk("R9 bp kept", 32'(bp), 32'd4);
        chk("R9 wel kept", 32'(wel), 32'd1);
        send(C_SE, 24'h07_0000, 8'h0, 32, 1, 1, "R5 code4 sector 7");
        complete();
        send(C_WREN, 24'h0, 8'h0, 8, 0, 0, "");
        send(C_SE, 24'h08_0000, 8'h0, 32, 1, 0, "R5 code4 sector 8");
        wp_n = 1'b1;
        send(C_WRSR, 24'h0, 8'h00, 16, 1, 1, "R7 unlocked status write");
        complete();
        chk("R7 bp cleared", 32'(bp), 32'd0);
        chk("R7 srwd cleared", 32'(srwd), 32'd0);

        // R6 chip erase allowed
        send(C_WREN, 24'h0, 8'h0, 8, 0, 0, "");
        send(C_BE, 24'h0, 8'h0, 8, 1, 1, "R6 chip erase code 0");
        chk("R12 arr_kind chip", 32'(arr_kind), 32'd3);
        complete();

        // R5 code 1
        send(C_WREN, 24'h0, 8'h0, 8, 0, 0, "");
        send(C_WRSR, 24'h0, 8'h04, 16, 1, 1, "R7 code 1");
        complete();
        send(C_WREN, 24'h0, 8'h0, 8, 0, 0, "");
        send(C_SE, 24'h0F_0000, 8'h0, 32, 1, 0, "R5 code1 sector 15");
        send(C_SE, 24'h0E_0000, 8'h0, 32, 1, 1, "R5 code1 sector 14");
        chk("R12 arr_kind sector", 32'(arr_kind), 32'd2);
        complete();

        // R5 code 5: all
        send(C_WREN, 24'h0, 8'h0, 8, 0, 0, "");
        send(C_WRSR, 24'h0, 8'h14, 16, 1, 1, "R7 code 5");
        complete();
        send(C_WREN, 24'h0, 8'h0, 8, 0, 0, "");
        send(C_SE, 24'h00_0000, 8'h0, 32, 1, 0, "R5 code5 sector 0");

        // R11 deep power-down
        send(C_DP, 24'h0, 8'h0, 8, 0, 0, "");
        chk("R11 dpd entered", 32'(dpd), 32'd1);
        send(C_WRDI, 24'h0, 8'h0, 8, 0, 0, "");
        chk("R11 wrdi ignored", 32'(wel), 32'd1);
        send(C_PP, 24'h0, 8'h0, 40, 0, 0, "");
        chk("R11 still asleep", 32'(dpd), 32'd1);
        send(C_RES, 24'h0, 8'h0, 8, 0, 0, "");
        chk("R11 wake", 32'(dpd), 32'd0);
        chk("R11 wel kept", 32'(wel), 32'd1);

        repeat (4) @(negedge clk);
        chk("R10 scoreboard drained", 32'(sb.size()), 32'd0);
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule